// File: doc/BRIEF.md
# Programmable Waveform Interface Engine

This block drives a parallel peripheral bus with bus cycles that are not fixed in hardware. A host loads up to four waveform programs into a small descriptor store. Each program is a list of states. A state either holds three control lines at programmed levels for a set number of clocks, or tests two ready inputs with a small logic function and branches on the result. The host then sets a transaction count, picks a program and starts the engine. The engine runs the program once per transaction until the count is exhausted, then returns the control lines to their idle levels and signals completion.

A state can also drive the 16-bit data bus from a host-set word, capture the incoming bus word, or advance a 9-bit bus address at its exit. A configuration bit selects an 8-bit or a 16-bit data width. A host abort returns the engine to idle on the next clock.

Top module: `gwf_engine`

## Requirements
- R1: After a synchronous reset, ctl_o, adr_o, bus_oe, bus_do, rd_data, rd_valid, done and irq are all zero, and the idle control level is 0.
- R2: A host write with hst_addr[7]=0 stores hst_wdata into descriptor byte hst_addr[1:0] of state hst_addr[4:2] of program hst_addr[6:5]. Byte 0 holds the duration or branch targets, byte 1 the opcode (bit0 decision, bit1 drive, bit2 sample, bit3 address increment), byte 2 the control levels in [2:0], and byte 3 the ready logic. A write to 0x8F with bit6 set starts program hst_wdata[1:0] at state 0 on that clock edge.
- R3: While running, ctl_o shows byte 2 [2:0] of the current state. A non-decision state lasts byte 0 clocks, and a byte 0 of 0 means 256 clocks.
- R4: A decision state lasts one clock. It takes A = rdy_i[byte3[2]] and B = rdy_i[byte3[3]] and combines them by byte3[1:0] (0 AND, 1 OR, 2 XOR, 3 XNOR). It goes to state byte0[5:3] when the result is 1 and to state byte0[2:0] when it is 0.
- R5: A non-decision state is followed by the next state index. Reaching index 7 ends one transaction, and the program restarts at state 0 if the count is not exhausted.
- R6: The transaction count is loaded from 0x80 (bits 23:16), 0x81 (bits 15:8) and 0x82 (bits 7:0). It is decremented at the end of each transaction. A start with a count of zero is ignored.
- R7: When the last transaction ends, the engine stops, irq is high for exactly one clock, and done goes high and stays high until the next accepted start.
- R8: When not running, ctl_o shows the idle level written to 0x84 [2:0].
- R9: A write to 0x8F with bit7 set stops a running program at that edge. No done and no irq follow, and abort takes priority over a start in the same write.
- R10: The address register is written at 0x85 (bits 7:0) and 0x86 bit0 (bit 8). It increments, wrapping at 9 bits, at the exit of any state with the increment opcode bit.
- R11: Register 0x83 bit0 selects the 16-bit width (1) or the 8-bit width (0). bus_oe is high during states with the drive bit, and bus_do carries the word from 0x87 (low) and 0x88 (high). A state with the sample bit captures bus_di at its exit, and rd_valid is high for the following clock. In 8-bit width the upper bytes of bus_do and rd_data are zero.
- R12: While a program runs, host writes other than to 0x8F are ignored, and a start command is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_we | input | 1 | Host register write strobe |
| hst_addr | input | 8 | Host register address |
| hst_wdata | input | 8 | Host write data |
| rdy_i | input | 2 | Ready inputs from the peripheral |
| ctl_o | output | 3 | Control outputs |
| adr_o | output | 9 | Bus address |
| bus_di | input | 16 | Data bus input |
| bus_do | output | 16 | Data bus output value |
| bus_oe | output | 1 | Data bus output enable |
| rd_data | output | 16 | Last captured bus word |
| rd_valid | output | 1 | One-clock strobe after a capture |
| done | output | 1 | Completion level |
| irq | output | 1 | One-clock completion pulse |

## Verification
The bench exercises the 256-clock meaning of a zero duration. A design that loaded the counter off by one would hold the line for 255 or 257 clocks. Each ready function is driven with moving ready patterns, and a swapped branch field or wrong function would send the program down the other path, giving the wrong control sequence. Host writes are made during a long running state, and a design that accepted them would change the count or the idle level. An abort is checked for cleanliness, since a careless design would also pulse irq. The 9-bit address wrap and the 8-bit masking of both data directions are checked, because a design without them would show stale upper bits.

// File: rtl/gwf_pkg.sv
package gwf_pkg;
    localparam int WF_N     = 4;
    localparam int ST_N     = 8;
    localparam int ST_W     = $clog2(ST_N);
    localparam int WF_W     = $clog2(WF_N);
    localparam int WORDS    = WF_N * ST_N;
    localparam int WIDX_W   = $clog2(WORDS);
    localparam int BADDR_W  = $clog2(WORDS * 4);
    localparam int CTL_N    = 3;
    localparam int RDY_N    = 2;
    localparam int RSEL_W   = $clog2(RDY_N);
    localparam int ADR_W    = 9;
    localparam int DAT_W    = 16;
    localparam int TC_W     = 24;
    localparam int TC_BYTES = TC_W / 8;
    localparam int END_ST   = ST_N - 1;

    // host register map
    localparam logic [7:0] HA_TC0  = 8'h80;
    localparam logic [7:0] HA_CFG  = 8'h83;
    localparam logic [7:0] HA_IDLE = 8'h84;
    localparam logic [7:0] HA_ADRL = 8'h85;
    localparam logic [7:0] HA_ADRH = 8'h86;
    localparam logic [7:0] HA_WDL  = 8'h87;
    localparam logic [7:0] HA_WDH  = 8'h88;
    localparam logic [7:0] HA_CMD  = 8'h8F;

    localparam int OP_DEC = 0;
    localparam int OP_DRV = 1;
    localparam int OP_SMP = 2;
    localparam int OP_INC = 3;

    typedef enum logic [1:0] {RF_AND, RF_OR, RF_XOR, RF_XNOR} rfn_e;

    typedef struct packed {
        logic [7:0] lgc_b;
        logic [7:0] ctl_b;
        logic [7:0] op_b;
        logic [7:0] arg_b;
    } st_word_t;

    typedef struct packed {
        logic            active;
        logic [WF_W-1:0] wf;
        logic [ST_W-1:0] st;
        logic [7:0]      cnt;
    } seq_t;

    function automatic logic ready_eval(st_word_t w, logic [RDY_N-1:0] rdy);
        logic a, b;
        a = rdy[w.lgc_b[2 +: RSEL_W]];
        b = rdy[w.lgc_b[3 +: RSEL_W]];
        case (rfn_e'(w.lgc_b[1:0]))
            RF_AND:  return a & b;
            RF_OR:   return a | b;
            RF_XOR:  return a ^ b;
            default: return ~(a ^ b);
        endcase
    endfunction

    function automatic logic [ST_W-1:0] next_state(st_word_t w, logic [ST_W-1:0] st,
                                                   logic [RDY_N-1:0] rdy);
        if (w.op_b[OP_DEC])
            return ready_eval(w, rdy) ? w.arg_b[ST_W +: ST_W] : w.arg_b[0 +: ST_W];
        return st + ST_W'(1);
    endfunction
endpackage

// File: rtl/gwf_desc_mem.sv
module gwf_desc_mem
    import gwf_pkg::*;
#(
    parameter int NWORDS = WORDS,
    localparam int IW = $clog2(NWORDS),
    localparam int BW = $clog2(NWORDS * 4)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           we,
    input  logic [BW-1:0]  waddr,
    input  logic [7:0]     wdata,
    input  logic [IW-1:0]  idx_a,
    input  logic [IW-1:0]  idx_b,
    output st_word_t       word_a,
    output st_word_t       word_b
);
    logic [31:0] mem [NWORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NWORDS; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr[BW-1:2]][8*waddr[1:0] +: 8] <= wdata;
        end
    end

    assign word_a = st_word_t'(mem[idx_a]);
    assign word_b = st_word_t'(mem[idx_b]);
endmodule

// File: rtl/gwf_seq.sv
module gwf_seq
    import gwf_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                go,
    input  logic                abort,
    input  logic [WF_W-1:0]     go_wf,
    input  logic [TC_BYTES-1:0] tc_we,
    input  logic [7:0]          tc_byte,
    input  logic [RDY_N-1:0]    rdy,
    input  st_word_t            cur_w,
    input  st_word_t            nxt_w,
    output logic [WIDX_W-1:0]   cur_idx,
    output logic [WIDX_W-1:0]   nxt_idx,
    output logic                busy,
    output logic                step,
    output logic                done,
    output logic                irq
);
    seq_t            q;
    logic [TC_W-1:0] tc;
    logic            ends;
    logic            pass_end;
    logic [ST_W-1:0] nst;
    logic [ST_W-1:0] tgt;
    logic            unused_bits;

    assign unused_bits = ^{cur_w.op_b[7:1], cur_w.ctl_b, cur_w.lgc_b[7:4],
                           cur_w.arg_b[7:2*ST_W], nxt_w.lgc_b, nxt_w.ctl_b, nxt_w.op_b};

    always_comb begin
        ends     = cur_w.op_b[OP_DEC] || (q.cnt == 8'd0);
        nst      = next_state(cur_w, q.st, rdy);
        pass_end = (nst == ST_W'(END_ST));
        tgt      = pass_end ? '0 : nst;
        step     = q.active && ends && !abort;
        cur_idx  = {q.wf, q.st};
        nxt_idx  = q.active ? {q.wf, tgt} : {go_wf, ST_W'(0)};
    end

    assign busy = q.active;

    always_ff @(posedge clk) begin
        if (rst) begin
            q    <= '0;
            tc   <= '0;
            done <= 1'b0;
            irq  <= 1'b0;
        end else begin
            irq <= 1'b0;
            for (int i = 0; i < TC_BYTES; i++)
                if (tc_we[i] && !q.active) tc[8*(TC_BYTES-1-i) +: 8] <= tc_byte;
            if (abort) begin
                q.active <= 1'b0;
            end else if (!q.active) begin
                if (go && tc != '0) begin
                    q.active <= 1'b1;
                    q.wf     <= go_wf;
                    q.st     <= '0;
                    q.cnt    <= nxt_w.arg_b - 8'd1;
                    done     <= 1'b0;
                end
            end else if (ends) begin
                if (pass_end) begin
                    tc <= tc - TC_W'(1);
                    if (tc == TC_W'(1)) begin
                        q.active <= 1'b0;
                        done     <= 1'b1;
                        irq      <= 1'b1;
                    end else begin
                        q.st  <= '0;
                        q.cnt <= nxt_w.arg_b - 8'd1;
                    end
                end else begin
                    q.st  <= nst;
                    q.cnt <= nxt_w.arg_b - 8'd1;
                end
            end else begin
                q.cnt <= q.cnt - 8'd1;
            end
        end
    end
endmodule

// File: rtl/gwf_engine.sv
module gwf_engine
    import gwf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hst_we,
    input  logic [7:0]        hst_addr,
    input  logic [7:0]        hst_wdata,
    input  logic [RDY_N-1:0]  rdy_i,
    output logic [CTL_N-1:0]  ctl_o,
    output logic [ADR_W-1:0]  adr_o,
    input  logic [DAT_W-1:0]  bus_di,
    output logic [DAT_W-1:0]  bus_do,
    output logic              bus_oe,
    output logic [DAT_W-1:0]  rd_data,
    output logic              rd_valid,
    output logic              done,
    output logic              irq
);
    st_word_t            cur_w, nxt_w;
    logic [WIDX_W-1:0]   cur_idx, nxt_idx;
    logic                busy, step, go, abort, desc_we;
    logic [TC_BYTES-1:0] tc_we;
    logic                wide_q;
    logic [CTL_N-1:0]    idle_q;
    logic [ADR_W-1:0]    adr_q;
    logic [DAT_W-1:0]    wdat_q;
    logic [DAT_W-1:0]    rd_q;
    logic                rdv_q;

    assign go      = hst_we && (hst_addr == HA_CMD) && hst_wdata[6];
    assign abort   = hst_we && (hst_addr == HA_CMD) && hst_wdata[7];
    assign desc_we = hst_we && !hst_addr[7] && !busy;

    for (genvar g = 0; g < TC_BYTES; g++) begin : g_tc
        assign tc_we[g] = hst_we && (hst_addr == HA_TC0 + 8'(g));
    end

    gwf_desc_mem u_mem (
        .clk    (clk),
        .rst    (rst),
        .we     (desc_we),
        .waddr  (hst_addr[BADDR_W-1:0]),
        .wdata  (hst_wdata),
        .idx_a  (cur_idx),
        .idx_b  (nxt_idx),
        .word_a (cur_w),
        .word_b (nxt_w)
    );

    gwf_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .go      (go),
        .abort   (abort),
        .go_wf   (hst_wdata[WF_W-1:0]),
        .tc_we   (tc_we),
        .tc_byte (hst_wdata),
        .rdy     (rdy_i),
        .cur_w   (cur_w),
        .nxt_w   (nxt_w),
        .cur_idx (cur_idx),
        .nxt_idx (nxt_idx),
        .busy    (busy),
        .step    (step),
        .done    (done),
        .irq     (irq)
    );

    function automatic logic [DAT_W-1:0] fit_width(logic w, logic [DAT_W-1:0] v);
        return w ? v : {{(DAT_W-8){1'b0}}, v[7:0]};
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wide_q <= 1'b0;
            idle_q <= '0;
            adr_q  <= '0;
            wdat_q <= '0;
            rd_q   <= '0;
            rdv_q  <= 1'b0;
        end else begin
            rdv_q <= 1'b0;
            if (hst_we && !busy) begin
                case (hst_addr)
                    HA_CFG:  wide_q           <= hst_wdata[0];
                    HA_IDLE: idle_q           <= hst_wdata[CTL_N-1:0];
                    HA_ADRL: adr_q[7:0]       <= hst_wdata;
                    HA_ADRH: adr_q[ADR_W-1:8] <= hst_wdata[ADR_W-9:0];
                    HA_WDL:  wdat_q[7:0]      <= hst_wdata;
                    HA_WDH:  wdat_q[15:8]     <= hst_wdata;
                    default: ;
                endcase
            end
            if (step && cur_w.op_b[OP_INC]) adr_q <= adr_q + ADR_W'(1);
            if (step && cur_w.op_b[OP_SMP]) begin
                rd_q  <= fit_width(wide_q, bus_di);
                rdv_q <= 1'b1;
            end
        end
    end

    assign ctl_o    = busy ? cur_w.ctl_b[CTL_N-1:0] : idle_q;
    assign bus_oe   = busy && cur_w.op_b[OP_DRV];
    assign bus_do   = fit_width(wide_q, wdat_q);
    assign adr_o    = adr_q;
    assign rd_data  = rd_q;
    assign rd_valid = rdv_q;
endmodule

// File: rtl/gwf_chk.sv
module gwf_chk
    import gwf_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             hst_we,
    input logic [7:0]       hst_addr,
    input logic [7:0]       hst_wdata,
    input logic             busy,
    input logic [CTL_N-1:0] ctl_o,
    input logic [CTL_N-1:0] idle_lvl,
    input logic [ADR_W-1:0] adr_o,
    input logic             bus_oe,
    input logic             done,
    input logic             irq,
    input logic             rd_valid
);
    // R9: abort lands in idle on the next clock with no completion pulse
    a_r9_abort_idle: assert property (@(posedge clk) disable iff (rst)
        (busy && hst_we && hst_addr == HA_CMD && hst_wdata[7])
        |=> (!busy && !irq && !bus_oe && ctl_o == idle_lvl));

    // R7: interrupt is a single-clock pulse
    a_r7_irq_single: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    // R7: done rises together with the interrupt
    a_r7_done_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> irq);

    // R7: interrupt only with done set
    a_r7_irq_done: assert property (@(posedge clk) disable iff (rst)
        irq |-> done);

    // R11: bus is only driven while a program runs
    a_r11_oe_busy: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> busy);

    // R11: capture strobe follows a running clock
    a_r11_rdv_run: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(busy));

    // R10: address holds while idle and not written by the host
    a_r10_adr_idle: assert property (@(posedge clk) disable iff (rst)
        (!busy && !(hst_we && (hst_addr == HA_ADRL || hst_addr == HA_ADRH)))
        |=> $stable(adr_o));
endmodule

bind gwf_engine gwf_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .hst_we    (hst_we),
    .hst_addr  (hst_addr),
    .hst_wdata (hst_wdata),
    .busy      (busy),
    .ctl_o     (ctl_o),
    .idle_lvl  (idle_q),
    .adr_o     (adr_o),
    .bus_oe    (bus_oe),
    .done      (done),
    .irq       (irq),
    .rd_valid  (rd_valid)
);

// File: tb/tb_gwf_engine.sv
`timescale 1ns/1ps
module tb_gwf_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hst_we = 1'b0;
    logic [7:0]  hst_addr = '0;
    logic [7:0]  hst_wdata = '0;
    logic [1:0]  rdy_i = '0;
    logic [2:0]  ctl_o;
    logic [8:0]  adr_o;
    logic [15:0] bus_di = '0;
    logic [15:0] bus_do;
    logic        bus_oe;
    logic [15:0] rd_data;
    logic        rd_valid;
    logic        done;
    logic        irq;

    always #2.5 clk = ~clk;

    gwf_engine dut (.*);

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit auto_in = 1'b0;
    bit finished = 1'b0;

    // reference model state
    int dm [128];
    int m_tc, m_busy, m_wf, m_st, m_cnt, m_adr, m_wide, m_idle, m_wdat;
    int m_done, m_irq, m_rdv, m_rd;

    function automatic int wb(int st, int lane);
        return dm[m_wf*32 + st*4 + lane];
    endfunction

    function automatic int dur(int st);
        return (wb(st, 0) == 0) ? 256 : wb(st, 0);
    endfunction

    task automatic model_reset();
        foreach (dm[i]) dm[i] = 0;
        m_tc = 0; m_busy = 0; m_wf = 0; m_st = 0; m_cnt = 0; m_adr = 0;
        m_wide = 0; m_idle = 0; m_wdat = 0; m_done = 0; m_irq = 0; m_rdv = 0; m_rd = 0;
    endtask

    task automatic model_step();
        int a, d, op, arg, lg, nxt;
        bit ra, rb, r, go, ab, leave;
        a = hst_addr; d = hst_wdata; go = 0; ab = 0; leave = 0; nxt = 0;
        m_irq = 0; m_rdv = 0;
        if (hst_we) begin
            if (a == 'h8F) begin ab = d[7]; go = d[6]; end
            else if (!m_busy) begin
                if (a < 128) dm[a] = d;
                else case (a)
                    'h80: m_tc = (m_tc & 'h00FFFF) | (d << 16);
                    'h81: m_tc = (m_tc & 'hFF00FF) | (d << 8);
                    'h82: m_tc = (m_tc & 'hFFFF00) | d;
                    'h83: m_wide = d & 1;
                    'h84: m_idle = d & 7;
                    'h85: m_adr = (m_adr & 'h100) | d;
                    'h86: m_adr = (m_adr & 'hFF) | ((d & 1) << 8);
                    'h87: m_wdat = (m_wdat & 'hFF00) | d;
                    'h88: m_wdat = (m_wdat & 'hFF) | (d << 8);
                    default: ;
                endcase
            end
        end
        if (ab) m_busy = 0;
        else if (!m_busy) begin
            if (go && m_tc != 0) begin
                m_busy = 1; m_wf = d & 3; m_st = 0; m_cnt = dur(0); m_done = 0;
            end
        end else begin
            op = wb(m_st, 1); arg = wb(m_st, 0);
            if (op & 1) begin
                lg = wb(m_st, 3);
                ra = rdy_i[(lg >> 2) & 1];
                rb = rdy_i[(lg >> 3) & 1];
                case (lg & 3)
                    0: r = ra && rb;
                    1: r = ra || rb;
                    2: r = ra != rb;
                    default: r = ra == rb;
                endcase
                nxt = r ? ((arg >> 3) & 7) : (arg & 7);
                leave = 1;
            end else if (m_cnt > 1) begin
                m_cnt--;
            end else begin
                leave = 1; nxt = m_st + 1;
            end
            if (leave) begin
                if (op & 4) begin m_rd = m_wide ? int'(bus_di) : int'(bus_di) & 255; m_rdv = 1; end
                if (op & 8) m_adr = (m_adr + 1) & 511;
                if (nxt == 7) begin
                    m_tc--;
                    if (m_tc == 0) begin m_busy = 0; m_done = 1; m_irq = 1; end
                    else begin m_st = 0; m_cnt = dur(0); end
                end else begin
                    m_st = nxt; m_cnt = dur(nxt);
                end
            end
        end
    endtask

    task automatic chk(string tag, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s got=%0h exp=%0h at cycle %0d", tag, what, got, exp, cyc);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (rst) model_reset();
        else model_step();
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            finish_run();
        end
    end

    // free-running stimulus on ready and bus input
    always @(negedge clk) begin
        if (auto_in) begin
            rdy_i  = {cyc[3], cyc[2]};
            bus_di = 16'(cyc * 16'h2F1B);
        end
    end

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            if (m_busy) chk((wb(m_st, 1) & 1) ? "R4" : "R3", "ctl_o", int'(ctl_o), wb(m_st, 2) & 7);
            else        chk("R8", "ctl_o", int'(ctl_o), m_idle);
            chk("R11", "bus_oe", int'(bus_oe), (m_busy && (wb(m_st, 1) & 2)) ? 1 : 0);
            chk("R11", "bus_do", int'(bus_do), m_wide ? m_wdat : (m_wdat & 255));
            chk("R10", "adr_o", int'(adr_o), m_adr);
            chk("R7", "done", int'(done), m_done);
            chk("R7", "irq", int'(irq), m_irq);
            chk("R11", "rd_valid", int'(rd_valid), m_rdv);
            chk("R11", "rd_data", int'(rd_data), m_rd);
        end
    end

    task automatic wr(int a, int d);
        @(negedge clk);
        hst_we = 1'b1; hst_addr = 8'(a); hst_wdata = 8'(d);
        @(negedge clk);
        hst_we = 1'b0;
    endtask

    task automatic set_st(int wf, int st, int arg, int op, int ctl, int lg);
        wr(wf*32 + st*4 + 0, arg);
        wr(wf*32 + st*4 + 1, op);
        wr(wf*32 + st*4 + 2, ctl);
        wr(wf*32 + st*4 + 3, lg);
    endtask

    task automatic set_tc(int v);
        wr('h80, (v >> 16) & 255);
        wr('h81, (v >> 8) & 255);
        wr('h82, v & 255);
    endtask

    task automatic wait_done(int limit);
        for (int i = 0; i < limit && !done; i++) @(negedge clk);
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1", "ctl_o", int'(ctl_o), 0);
        chk("R1", "adr_o", int'(adr_o), 0);
        chk("R1", "bus_oe", int'(bus_oe), 0);
        chk("R1", "bus_do", int'(bus_do), 0);
        chk("R1", "done/irq", int'({done, irq, rd_valid}), 0);

        // program 0: drive, sample+increment, AND decision
        set_st(0, 0, 2, 'h2, 1, 0);
        set_st(0, 1, 1, 'hC, 2, 0);
        set_st(0, 2, (7 << 3) | 2, 'h1, 4, 'h8);
        // program 1: 256-clock state then OR decision
        set_st(1, 0, 0, 0, 5, 0);
        set_st(1, 1, (7 << 3) | 1, 'h1, 6, 'h1);
        // program 2: XOR and XNOR branching
        set_st(2, 0, (3 << 3) | 5, 'h1, 1, 'hA);
        set_st(2, 3, 1, 'h8, 2, 0);
        set_st(2, 4, (7 << 3) | 0, 'h1, 3, 'hB);
        set_st(2, 5, 2, 'h2, 4, 0);
        set_st(2, 6, 1, 'h4, 7, 0);
        // program 3: straight run of seven states
        for (int k = 0; k < 7; k++) set_st(3, k, k + 1, 'h8, (k + 1) & 7, 0);

        wr('h83, 1); wr('h84, 2); wr('h87, 'hEF); wr('h88, 'hBE);
        wr('h85, 'h10); wr('h86, 0);
        set_tc(3);
        auto_in = 1'b1;
        wr('h8F, 'h40 | 0);
        chk("R2", "first state ctl", int'(ctl_o), 1);
        wait_done(2000);
        chk("R7", "irq at completion", int'(irq), 1);
        @(negedge clk);
        chk("R7", "irq cleared", int'(irq), 0);
        chk("R7", "done held", int'(done), 1);
        chk("R8", "idle level", int'(ctl_o), 2);

        // R6: start with exhausted count is ignored
        wr('h8F, 'h40 | 3);
        repeat (2) @(negedge clk);
        chk("R6", "no start ctl", int'(ctl_o), 2);
        chk("R6", "done kept", int'(done), 1);

        // R5: two passes of seven states, 1+2+..+7 clocks each
        set_tc(2);
        wr('h8F, 'h40 | 3);
        n = 0;
        while (!done && n < 1000) begin n++; @(negedge clk); end
        chk("R5", "run length", n, 56);

        // R3: zero duration lasts 256 clocks; ready low keeps program 1 looping
        auto_in = 1'b0; rdy_i = 2'b00;
        set_tc(1);
        wr('h8F, 'h40 | 1);
        n = 0;
        while (ctl_o == 3'd5 && n < 400) begin n++; @(negedge clk); end
        chk("R3", "zero duration clocks", n, 256);
        // R12: writes while running are ignored
        wr('h82, 9); wr('h84, 7); wr('h85, 'h55); wr(1*32 + 2, 0); wr('h8F, 'h40 | 3);
        chk("R12", "still in program 1", int'(ctl_o), 6);
        // R9: abort
        wr('h8F, 'h80);
        chk("R9", "abort ctl idle", int'(ctl_o), 2);
        chk("R9", "abort no done", int'({done, irq}), 0);
        chk("R12", "address unchanged", int'(adr_o), 'h10 + 3*1 + 14);
        wr('h8F, 'h40 | 3);
        n = 0;
        while (!done && n < 1000) begin n++; @(negedge clk); end
        chk("R12", "count write ignored", n, 28);

        // R11: narrow width, fixed ready low, constant bus input
        wr('h83, 0);
        bus_di = 16'hABCD;
        set_tc(4);
        wr('h8F, 'h40 | 2);
        wait_done(1000);
        @(negedge clk);
        chk("R11", "narrow capture", int'(rd_data), 'h00CD);
        chk("R11", "narrow drive", int'(bus_do), 'h00EF);

        // R4: ready patterns moving through XOR/XNOR paths
        auto_in = 1'b1;
        set_tc(4);
        wr('h8F, 'h40 | 2);
        wait_done(4000);
        chk("R4", "decision run completes", int'(done), 1);

        // R10: 9-bit address wrap
        wr('h85, 'hFF); wr('h86, 1);
        set_tc(1);
        wr('h8F, 'h40 | 3);
        wait_done(1000);
        @(negedge clk);
        chk("R10", "address wrap", int'(adr_o), 6);

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule